// File: doc/BRIEF.md
# Post-Update Indexed Load Unit

This block carries out one indexed load with post-update on a machine with 64-bit registers. A caller presents the decoded access size, a sign-extension flag and three register indices (destination, base, index), then pulses `start`. The unit reads the base and index registers through two read ports into an external register file. It issues one memory read at the unmodified base value. When the memory answers, it writes the size-extended load data to the destination register and, in the same cycle, writes base plus index back to the base register.

A form whose base index is 0, or whose base index equals the destination index, is rejected. In that case the unit raises an invalid flag and makes neither a memory access nor a register write. A memory response that carries an error also suppresses both writes and is reported with the completion pulse.

The controller has six named states. ST_IDLE waits for a start. ST_READ captures the base and the sum. ST_REQ issues the request. ST_WAIT waits for the response. ST_WB performs the two writes. ST_DONE pulses completion. The transitions are:
- ST_IDLE to ST_READ on a valid start.
- ST_IDLE to ST_DONE on an invalid start.
- ST_READ to ST_REQ, and ST_REQ to ST_WAIT, unconditionally.
- ST_WAIT to ST_WB on a clean response.
- ST_WAIT to ST_DONE on an error response.
- ST_WB to ST_DONE, and ST_DONE to ST_IDLE, unconditionally.

Top module: `pul_load_unit`

## Requirements
- R1: If the base index is 0 or equals the destination index, `done` and `invalid` are high one cycle after the start. No `mem_req`, `rt_we` or `ra_we` occurs for that operation.
- R2: For a valid form, `mem_req` is high for exactly one cycle, two cycles after the start. In that cycle `mem_addr` equals the base register value read before the access (the index is not added), and `mem_size` equals the requested size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes).
- R3: On write-back, `ra_waddr` is the base index and `ra_wdata` is old base plus old index, modulo 2^64. This also holds when the index register is the base register itself.
- R4: Size code 0 writes the response's low 8 bits into the destination and clears bits 63:8, whatever the sign flag.
- R5: Size code 1 places the low 16 bits. Bits 63:16 are cleared when the sign flag is 0 and copy bit 15 when it is 1.
- R6: Size code 2 places the low 32 bits. Bits 63:32 are cleared when the sign flag is 0 and copy bit 31 when it is 1.
- R7: Size code 3 writes all 64 response bits unchanged.
- R8: Response bits above the requested size have no effect on the destination value.
- R9: One cycle after a clean `mem_valid`, `rt_we` and `ra_we` are high together for exactly one cycle, with `rt_waddr` equal to the destination index. `done` follows in the next cycle with `err` and `invalid` low.
- R10: A response with `mem_err` high produces no register write. `done` and `err` are high one cycle after that response.
- R11: `busy` is high from the cycle after an accepted start through the `done` cycle, then low. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_size | input | 2 | Access size code |
| op_signed | input | 1 | Sign-extend the loaded value |
| rt_sel | input | 5 | Destination register index |
| ra_sel | input | 5 | Base register index |
| rb_sel | input | 5 | Index register index |
| rf_a_addr | output | 5 | Register file read port A index (base) |
| rf_a_data | input | 64 | Register file read port A data |
| rf_b_addr | output | 5 | Register file read port B index (index register) |
| rf_b_data | input | 64 | Register file read port B data |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | 64 | Memory read address |
| mem_size | output | 2 | Memory read size code |
| mem_valid | input | 1 | Memory response strobe |
| mem_err | input | 1 | Memory response error |
| mem_rdata | input | 64 | Right-aligned response data |
| rt_we | output | 1 | Destination write enable |
| rt_waddr | output | 5 | Destination write index |
| rt_wdata | output | 64 | Destination write data |
| ra_we | output | 1 | Base write enable |
| ra_waddr | output | 5 | Base write index |
| ra_wdata | output | 64 | Base write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| invalid | output | 1 | Invalid form, valid with done |
| err | output | 1 | Memory error, valid with done |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path and 5-bit register indices, which gives 32 registers. This width makes all four access sizes reachable, including the full-width case with no extension. It also lets the base-plus-index sum wrap past 2^64. The 32-entry index space lets random operations hit both invalid-form conditions, the case where the index register is the base register, and response delays of zero to three cycles.

// File: rtl/pul_pkg.sv
package pul_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } pul_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_REQ,
        ST_WAIT,
        ST_WB,
        ST_DONE
    } pul_state_e;

    localparam int unsigned PUL_NUM_SIZES = 4;
endpackage

// File: rtl/pul_form_check.sv
module pul_form_check #(
    parameter int unsigned RIDX_W = 5
) (
    input  logic [RIDX_W-1:0] dst_idx,
    input  logic [RIDX_W-1:0] base_idx,
    output logic              bad_form
);
    localparam logic [RIDX_W-1:0] ZERO_IDX = '0;

    always_comb begin
        bad_form = (base_idx == ZERO_IDX) || (base_idx == dst_idx);
    end
endmodule

// File: rtl/pul_extend.sv
module pul_extend
    import pul_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] raw,
    input  logic [1:0]      size,
    input  logic            sign_en,
    output logic [XLEN-1:0] ext
);
    logic [XLEN-1:0] lane [PUL_NUM_SIZES];

    for (genvar k = 0; k < PUL_NUM_SIZES; k++) begin : g_lane
        localparam int unsigned W = 8 << k;
        if (W >= XLEN) begin : g_full
            assign lane[k] = raw;
        end else begin : g_part
            // the narrowest lane never sign-extends
            logic fill;
            assign fill    = (k != 0) && sign_en && raw[W-1];
            assign lane[k] = {{(XLEN-W){fill}}, raw[W-1:0]};
        end
    end

    always_comb begin
        ext = lane[size];
    end
endmodule

// File: rtl/pul_ctrl.sv
module pul_ctrl
    import pul_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bad_form,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic [RIDX_W-1:0] rt_sel,
    input  logic [RIDX_W-1:0] ra_sel,
    input  logic [RIDX_W-1:0] rb_sel,
    output logic [RIDX_W-1:0] rf_a_addr,
    input  logic [XLEN-1:0]   rf_a_data,
    output logic [RIDX_W-1:0] rf_b_addr,
    input  logic [XLEN-1:0]   rf_b_data,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    output logic [1:0]        mem_size,
    input  logic              mem_valid,
    input  logic              mem_err,
    input  logic [XLEN-1:0]   ext_data,
    output logic [1:0]        size_q_o,
    output logic              sign_q_o,
    output logic              rt_we,
    output logic [RIDX_W-1:0] rt_waddr,
    output logic [XLEN-1:0]   rt_wdata,
    output logic              ra_we,
    output logic [RIDX_W-1:0] ra_waddr,
    output logic [XLEN-1:0]   ra_wdata,
    output logic              busy,
    output logic              done,
    output logic              invalid,
    output logic              err
);
    pul_state_e        state_q, state_d;
    logic [1:0]        size_q;
    logic              sign_q;
    logic [RIDX_W-1:0] rt_q, ra_q, rb_q;
    logic [XLEN-1:0]   addr_q, sum_q, load_q;
    logic              inv_q, err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = bad_form ? ST_DONE : ST_READ;
            ST_READ: state_d = ST_REQ;
            ST_REQ:  state_d = ST_WAIT;
            ST_WAIT: if (mem_valid) state_d = mem_err ? ST_DONE : ST_WB;
            ST_WB:   state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= '0;
            sign_q <= 1'b0;
            rt_q   <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            addr_q <= '0;
            sum_q  <= '0;
            load_q <= '0;
            inv_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                size_q <= op_size;
                sign_q <= op_signed;
                rt_q   <= rt_sel;
                ra_q   <= ra_sel;
                rb_q   <= rb_sel;
                inv_q  <= bad_form;
                err_q  <= 1'b0;
            end
            if (state_q == ST_READ) begin
                addr_q <= rf_a_data;
                sum_q  <= rf_a_data + rf_b_data;
            end
            if (state_q == ST_WAIT && mem_valid) begin
                load_q <= ext_data;
                err_q  <= mem_err;
            end
        end
    end

    always_comb begin
        rf_a_addr = ra_q;
        rf_b_addr = rb_q;
        mem_addr  = addr_q;
        mem_size  = size_q;
        size_q_o  = size_q;
        sign_q_o  = sign_q;
        rt_waddr  = rt_q;
        rt_wdata  = load_q;
        ra_waddr  = ra_q;
        ra_wdata  = sum_q;
        mem_req   = (state_q == ST_REQ);
        rt_we     = (state_q == ST_WB);
        ra_we     = (state_q == ST_WB);
        done      = (state_q == ST_DONE);
        invalid   = (state_q == ST_DONE) && inv_q;
        err       = (state_q == ST_DONE) && err_q;
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/pul_load_unit.sv
module pul_load_unit
    import pul_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic [RIDX_W-1:0] rt_sel,
    input  logic [RIDX_W-1:0] ra_sel,
    input  logic [RIDX_W-1:0] rb_sel,
    output logic [RIDX_W-1:0] rf_a_addr,
    input  logic [XLEN-1:0]   rf_a_data,
    output logic [RIDX_W-1:0] rf_b_addr,
    input  logic [XLEN-1:0]   rf_b_data,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    output logic [1:0]        mem_size,
    input  logic              mem_valid,
    input  logic              mem_err,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              rt_we,
    output logic [RIDX_W-1:0] rt_waddr,
    output logic [XLEN-1:0]   rt_wdata,
    output logic              ra_we,
    output logic [RIDX_W-1:0] ra_waddr,
    output logic [XLEN-1:0]   ra_wdata,
    output logic              busy,
    output logic              done,
    output logic              invalid,
    output logic              err
);
    logic            bad_form;
    logic [1:0]      size_q;
    logic            sign_q;
    logic [XLEN-1:0] ext_data;

    pul_form_check #(.RIDX_W(RIDX_W)) u_form (
        .dst_idx  (rt_sel),
        .base_idx (ra_sel),
        .bad_form (bad_form)
    );

    pul_extend #(.XLEN(XLEN)) u_ext (
        .raw     (mem_rdata),
        .size    (size_q),
        .sign_en (sign_q),
        .ext     (ext_data)
    );

    pul_ctrl #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bad_form  (bad_form),
        .op_size   (op_size),
        .op_signed (op_signed),
        .rt_sel    (rt_sel),
        .ra_sel    (ra_sel),
        .rb_sel    (rb_sel),
        .rf_a_addr (rf_a_addr),
        .rf_a_data (rf_a_data),
        .rf_b_addr (rf_b_addr),
        .rf_b_data (rf_b_data),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_valid (mem_valid),
        .mem_err   (mem_err),
        .ext_data  (ext_data),
        .size_q_o  (size_q),
        .sign_q_o  (sign_q),
        .rt_we     (rt_we),
        .rt_waddr  (rt_waddr),
        .rt_wdata  (rt_wdata),
        .ra_we     (ra_we),
        .ra_waddr  (ra_waddr),
        .ra_wdata  (ra_wdata),
        .busy      (busy),
        .done      (done),
        .invalid   (invalid),
        .err       (err)
    );
endmodule

// File: rtl/pul_load_unit_chk.sv
module pul_load_unit_chk #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              rt_we,
    input logic [RIDX_W-1:0] rt_waddr,
    input logic              ra_we,
    input logic [RIDX_W-1:0] ra_waddr,
    input logic              busy,
    input logic              done,
    input logic              invalid,
    input logic              err
);
    // R1
    inv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> done && !rt_we && !ra_we && !mem_req);
    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R9
    wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |-> ra_we && busy);
    // R9
    wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |=> done && !err && !invalid && !rt_we);
    // R9
    wb_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |-> (rt_waddr != ra_waddr) && (ra_waddr != '0));
    // R10
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && !invalid && !rt_we);
    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R11
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R11
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind pul_load_unit pul_load_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mem_req  (mem_req),
    .rt_we    (rt_we),
    .rt_waddr (rt_waddr),
    .ra_we    (ra_we),
    .ra_waddr (ra_waddr),
    .busy     (busy),
    .done     (done),
    .invalid  (invalid),
    .err      (err)
);

// File: tb/tb_pul_load_unit.sv
module tb_pul_load_unit;
    localparam int XLEN = 64;
    localparam int RW   = 5;
    localparam int NREG = 1 << RW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            start = 0, op_signed = 0;
    logic [1:0]      op_size = 0;
    logic [RW-1:0]   rt_sel = 0, ra_sel = 0, rb_sel = 0;
    logic [RW-1:0]   rf_a_addr, rf_b_addr;
    logic [XLEN-1:0] rf_a_data, rf_b_data;
    logic            mem_req, mem_valid = 0, mem_err = 0;
    logic [XLEN-1:0] mem_addr, mem_rdata = 0;
    logic [1:0]      mem_size;
    logic            rt_we, ra_we, busy, done, invalid, err;
    logic [RW-1:0]   rt_waddr, ra_waddr;
    logic [XLEN-1:0] rt_wdata, ra_wdata;

    logic [XLEN-1:0] regs [NREG];
    assign rf_a_data = regs[rf_a_addr];
    assign rf_b_data = regs[rf_b_addr];

    int checks = 0, fails = 0;

    pul_load_unit #(.XLEN(XLEN), .RIDX_W(RW)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(logic [1:0] s, logic sx, logic [63:0] d);
        case (s)
            2'd0:    return {56'b0, d[7:0]};
            2'd1:    return sx ? {{48{d[15]}}, d[15:0]} : {48'b0, d[15:0]};
            2'd2:    return sx ? {{32{d[31]}}, d[31:0]} : {32'b0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic string size_req(logic [1:0] s);
        case (s)
            2'd0: return "R4/R8";
            2'd1: return "R5/R8";
            2'd2: return "R6/R8";
            default: return "R7";
        endcase
    endfunction

    task automatic run_op(input logic [1:0] s, input logic sx, input int rt, input int ra, input int rb,
                          input logic [63:0] d, input logic e, input int dly, input bit poke);
        logic [63:0] a0, b0, exp_rt;
        bit inv;
        int vdue, reqs, wrs, dcyc;
        a0 = regs[ra]; b0 = regs[rb];
        inv = (ra == 0) || (ra == rt);
        exp_rt = exp_load(s, sx, d);
        vdue = -100; reqs = 0; wrs = 0; dcyc = -1;
        @(negedge clk);
        start = 1; op_size = s; op_signed = sx;
        rt_sel = RW'(rt); ra_sel = RW'(ra); rb_sel = RW'(rb);
        @(negedge clk);
        start = 0;
        for (int c = 1; c < 40 && dcyc < 0; c++) begin
            chk(busy == 1'b1, "R11 busy while active", 64'(busy), 64'd1);
            if (mem_req) begin
                reqs++;
                chk(!inv && c == 2, "R2 request cycle", 64'(c), 64'd2);
                chk(mem_addr == a0, "R2 address is old base", mem_addr, a0);
                chk(mem_size == s, "R2 size code", 64'(mem_size), 64'(s));
                vdue = c + 1 + dly;
            end
            if (rt_we || ra_we) begin
                wrs++;
                chk(rt_we && ra_we, "R9 writes together", {62'b0, rt_we, ra_we}, 64'd3);
                chk(!e && c == vdue + 1, "R9/R10 write cycle", 64'(c), 64'(vdue + 1));
                chk(rt_waddr == RW'(rt), "R9 dest index", 64'(rt_waddr), 64'(rt));
                chk(rt_wdata == exp_rt, size_req(s), rt_wdata, exp_rt);
                chk(ra_waddr == RW'(ra), "R3 base index", 64'(ra_waddr), 64'(ra));
                chk(ra_wdata == a0 + b0, "R3 sum", ra_wdata, a0 + b0);
                regs[rt] = rt_wdata;
                regs[ra] = ra_wdata;
            end
            if (done) begin
                dcyc = c;
                if (inv) begin
                    chk(c == 1 && invalid && !err, "R1 invalid flag", {62'b0, invalid, err}, 64'd2);
                end else if (e) begin
                    chk(c == vdue + 1 && err && !invalid, "R10 error done", 64'(c), 64'(vdue + 1));
                end else begin
                    chk(c == vdue + 2 && !err && !invalid, "R9 done after writes", 64'(c), 64'(vdue + 2));
                end
            end
            mem_valid = (c == vdue);
            mem_err   = e;
            mem_rdata = d;
            start     = poke && (c == 1);
            if (start) begin
                op_size = ~s; rt_sel = RW'(rt + 1); ra_sel = RW'(0); rb_sel = RW'(rt);
            end
            @(negedge clk);
        end
        start = 0; mem_valid = 0;
        chk(dcyc > 0, "R11 completion seen", 64'(dcyc), 64'd1);
        chk(reqs == (inv ? 0 : 1), "R1/R2 request count", 64'(reqs), 64'(inv ? 0 : 1));
        chk(wrs == ((inv || e) ? 0 : 1), "R1/R10 write count", 64'(wrs), 64'((inv || e) ? 0 : 1));
        chk(!busy && !done, "R11 idle after done", {62'b0, busy, done}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NREG; i++) regs[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !rt_we && !ra_we, "R11 reset state",
            {59'b0, busy, done, mem_req, rt_we, ra_we}, 64'd0);

        // R1 base index zero, and base equal to destination
        run_op(2'd3, 0, 5, 0, 6, 64'h1, 0, 0, 0);
        run_op(2'd1, 1, 7, 7, 2, 64'h2, 0, 1, 0);
        // R4 byte with sign flag set and dirty upper bits (R8)
        run_op(2'd0, 1, 3, 4, 5, 64'hFFFF_FFFF_FFFF_FF80, 0, 0, 0);
        // R5 half, both extension kinds
        run_op(2'd1, 1, 3, 4, 5, 64'h1234_5678_9ABC_8001, 0, 2, 0);
        run_op(2'd1, 0, 3, 4, 5, 64'h1234_5678_9ABC_8001, 0, 1, 0);
        // R6 word, both extension kinds
        run_op(2'd2, 1, 8, 9, 10, 64'hAAAA_5555_8000_0001, 0, 3, 0);
        run_op(2'd2, 0, 8, 9, 10, 64'hAAAA_5555_8000_0001, 0, 0, 0);
        // R7 doubleword
        run_op(2'd3, 1, 11, 12, 13, 64'hFEDC_BA98_7654_3210, 0, 1, 0);
        // R3 index equals base, and a wrapping sum
        regs[14] = 64'hFFFF_FFFF_FFFF_FFF0;
        run_op(2'd3, 0, 15, 14, 14, 64'h5, 0, 0, 0);
        // R10 error response
        run_op(2'd2, 1, 16, 17, 18, 64'hFFFF_FFFF, 1, 2, 0);
        // R11 start while busy is ignored
        run_op(2'd1, 0, 19, 20, 21, 64'h0000_0000_0000_7FFF, 0, 2, 1);

        for (int n = 0; n < 200; n++) begin
            int rt, ra, rb;
            rt = int'($urandom_range(NREG - 1));
            ra = int'($urandom_range(NREG - 1));
            rb = int'($urandom_range(NREG - 1));
            if ($urandom_range(9) == 0) ra = rt;
            run_op(2'($urandom_range(3)), 1'($urandom_range(1)), rt, ra, rb,
                   {$urandom, $urandom}, ($urandom_range(7) == 0), int'($urandom_range(3)),
                   ($urandom_range(5) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule